// File: doc/BRIEF.md
# Extension Limit Table Generator

This block fills a table of child-extension limits for a breadth-first tree-search detector. It runs once per channel frame, before the search starts. For every tree layer and every surviving-parent rank it computes how many children that parent may extend. The limit shrinks as the parent's rank grows, because parents are ranked by ascending partial distance and a higher rank is less reliable. It also shrinks as the layer's diagonal channel gain grows. A tuning factor sets how loose the limits are overall.

For layer i and parent rank k (k counts from 1), the unclamped limit is floor(beta * (M - k/M) * g_i). Here M is the real constellation size and g_i is the reciprocal of the layer's diagonal coefficient, supplied by the preprocessing stage. A negative result gives 0, which trims that parent's branch. A result above M is held at M, so every child is extended. The table is captured into registers and stays readable through a combinational read port until the next frame is started.

Top module: `ext_limit_calc`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every table entry reads 0.
- R2: A `start` pulse while idle raises `busy` on the next cycle. The table is written one entry per cycle, rank-major within each layer. `done` reads 1 exactly LAYERS*KMAX cycles after the edge that sampled `start`, at which point `busy` is 0. `busy` and `done` are never 1 together.
- R3: The entry at `rd_layer`=i, `rd_rank`=k-1 equals floor(beta/256 * (M - k/M) * g_i/256). Here `beta` and g_i are unsigned with 8 fractional bits, and g_i is `inv_gain[i*16 +: 16]`.
- R4: A value above M is stored as M.
- R5: A negative value (k > M*M) is stored as 0.
- R6: `mode` selects M: 0 gives 2, 1 gives 4, 2 gives 8, and 3 is treated as 8.
- R7: Ranks above `num_parents` are stored as 0. A `num_parents` above KMAX acts as KMAX.
- R8: The inputs are captured on the accepted `start`. Input changes and `start` pulses while `busy` is 1 have no effect on the table or on the completion time.
- R9: `done` stays 1 and the table keeps its values until the next accepted `start`, which clears `done`.
- R10: Within a layer, the limit never increases from one rank to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a frame computation (accepted when idle) |
| mode | input | 2 | Constellation select: 0 QPSK, 1 16-QAM, 2/3 64-QAM |
| beta | input | 12 | Tuning factor, unsigned, 8 fractional bits |
| num_parents | input | 5 | Number of surviving parents K |
| inv_gain | input | 128 | Per-layer reciprocal diagonal gain, 16 bits each, 8 fractional bits |
| rd_layer | input | 3 | Table read layer index |
| rd_rank | input | 4 | Table read rank index (rank minus 1) |
| rd_limit | output | 4 | Limit stored at the read address |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Table complete for the last frame |

## Verification
The assertions assume that `start` is only meaningful while idle, and that `mode`, `beta`, `num_parents` and `inv_gain` may change at any time without affecting a running frame. The rank-monotonicity and clamp properties also assume non-negative gains, which the unsigned input formats guarantee. The stimulus draws beta and each layer's gain from spans of varying bit width, so that small, mid-range and saturating products all occur. It also changes inputs and pulses `start` in the middle of a run to exercise the capture rule.

// File: rtl/ext_lim_pkg.sv
// Package: shared constants, constellation mode type and helpers for the
// extension limit table generator. Assumes real constellation sizes are
// powers of two no larger than 8.
package ext_lim_pkg;

    localparam int LIM_W = 4;

    typedef enum logic [1:0] {
        CST_QPSK   = 2'd0,
        CST_QAM16  = 2'd1,
        CST_QAM64  = 2'd2,
        CST_QAM64B = 2'd3
    } cst_mode_e;

    // Real constellation size for a mode
    function automatic logic [LIM_W-1:0] omega_of(input cst_mode_e m);
        case (m)
            CST_QPSK:  return LIM_W'(2);
            CST_QAM16: return LIM_W'(4);
            default:   return LIM_W'(8);
        endcase
    endfunction

    // log2 of the real constellation size
    function automatic logic [1:0] omega_lg(input cst_mode_e m);
        case (m)
            CST_QPSK:  return 2'd1;
            CST_QAM16: return 2'd2;
            default:   return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/lim_seq.sv
// Sequencer: accepts a start pulse while idle, then walks every
// (layer, rank) pair, rank-major within a layer, one per cycle.
// Raises done after the last pair and holds it until the next start.
// Assumes LAYERS >= 2 and KMAX >= 2.
module lim_seq #(
    parameter int LAYERS = 8,
    parameter int KMAX   = 16,
    localparam int LAY_W  = $clog2(LAYERS),
    localparam int KIDX_W = $clog2(KMAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              cap_en,
    output logic              wr_en,
    output logic [LAY_W-1:0]  layer_idx,
    output logic [KIDX_W-1:0] rank_idx
);

    logic last_rank;
    logic last_layer;

    // Decode end-of-row and end-of-table positions
    always_comb begin
        last_rank  = (rank_idx == KIDX_W'(KMAX - 1));
        last_layer = (layer_idx == LAY_W'(LAYERS - 1));
        cap_en     = start && !busy;
        wr_en      = busy;
    end

    // Walk counters and busy/done state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            layer_idx <= '0;
            rank_idx  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy      <= 1'b1;
                done      <= 1'b0;
                layer_idx <= '0;
                rank_idx  <= '0;
            end
        end else if (last_rank) begin
            rank_idx <= '0;
            if (last_layer) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                layer_idx <= layer_idx + 1'b1;
            end
        end else begin
            rank_idx <= rank_idx + 1'b1;
        end
    end

    assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    assert_done_after_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

// File: rtl/lim_arith.sv
// Datapath: computes one clamped limit per cycle,
// floor(beta * (M - k/M) * g), with beta and g unsigned Q.FRAC and the
// (M - k/M) term exact in 3 fractional bits. Purely combinational.
// Assumes M is a power of two up to 8, so k/M is exact in 3 fractional bits.
module lim_arith
    import ext_lim_pkg::*;
#(
    parameter int KMAX   = 16,
    parameter int BETA_W = 12,
    parameter int INV_W  = 16,
    parameter int FRAC   = 8,
    localparam int KIDX_W = $clog2(KMAX),
    localparam int NPAR_W = $clog2(KMAX + 1)
) (
    input  logic [1:0]        mode,
    input  logic [BETA_W-1:0] beta,
    input  logic [INV_W-1:0]  inv_gain,
    input  logic [NPAR_W-1:0] num_parents,
    input  logic [KIDX_W-1:0] rank_idx,
    output logic [LIM_W-1:0]  limit
);

    localparam int TERM_W = KIDX_W + 8;
    localparam int GAIN_W = BETA_W + INV_W;
    localparam int PROD_W = GAIN_W + TERM_W + 1;
    localparam int SHIFT  = 2 * FRAC + 3;

    cst_mode_e                 cmode;
    logic [LIM_W-1:0]          omega;
    logic [1:0]                k_sh;
    logic [KIDX_W:0]           rank;
    logic                      active;
    logic [TERM_W-1:0]         om_q3;
    logic [TERM_W-1:0]         k_q3;
    logic signed [TERM_W-1:0]  term;
    logic [GAIN_W-1:0]         gain;
    logic signed [PROD_W-1:0]  prod;
    logic signed [PROD_W-1:0]  whole;

    // Constellation constants and rank decoding
    always_comb begin
        cmode  = cst_mode_e'(mode);
        omega  = omega_of(cmode);
        k_sh   = 2'd3 - omega_lg(cmode);
        rank   = {1'b0, rank_idx} + 1'b1;
        active = (32'(rank) <= 32'(num_parents));
    end

    // Reliability term (M - k/M) in 3 fractional bits, may go negative
    always_comb begin
        om_q3 = TERM_W'(omega) << 3;
        k_q3  = TERM_W'(rank) << k_sh;
        term  = signed'(om_q3 - k_q3);
    end

    // Full-precision product and integer part
    always_comb begin
        gain  = GAIN_W'(beta) * GAIN_W'(inv_gain);
        prod  = signed'(PROD_W'(gain)) * PROD_W'(term);
        whole = prod >>> SHIFT;
    end

    // Floor and clamp into 0..M
    always_comb begin
        if (!active || prod <= 0) begin
            limit = '0;
        end else if (whole > signed'(PROD_W'(omega))) begin
            limit = omega;
        end else begin
            limit = whole[LIM_W-1:0];
        end
    end

endmodule

// File: rtl/lim_table.sv
// Limit table: one register per (layer, rank), written one entry per
// cycle, read combinationally. Cleared only by reset.
// Assumes read addresses beyond the table are not used (they read 0).
module lim_table
    import ext_lim_pkg::*;
#(
    parameter int LAYERS = 8,
    parameter int KMAX   = 16,
    localparam int LAY_W  = $clog2(LAYERS),
    localparam int KIDX_W = $clog2(KMAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LAY_W-1:0]  wr_layer,
    input  logic [KIDX_W-1:0] wr_rank,
    input  logic [LIM_W-1:0]  wr_data,
    input  logic [LAY_W-1:0]  rd_layer,
    input  logic [KIDX_W-1:0] rd_rank,
    output logic [LIM_W-1:0]  rd_data
);

    logic [LIM_W-1:0] tbl [LAYERS][KMAX];

    for (genvar l = 0; l < LAYERS; l++) begin : g_layer
        for (genvar r = 0; r < KMAX; r++) begin : g_rank
            // Hold one entry, load when the walk addresses it
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tbl[l][r] <= '0;
                end else if (wr_en && wr_layer == LAY_W'(l) && wr_rank == KIDX_W'(r)) begin
                    tbl[l][r] <= wr_data;
                end
            end
        end
    end

    // Combinational read port
    always_comb begin
        if (32'(rd_layer) < LAYERS && 32'(rd_rank) < KMAX) begin
            rd_data = tbl[rd_layer][rd_rank];
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/ext_limit_calc.sv
// Top: extension limit table generator. Captures the frame inputs on an
// accepted start, steps the datapath over every (layer, rank) pair and
// stores the clamped limits in the table.
// Assumes inputs are unsigned fixed point with FRAC fractional bits.
module ext_limit_calc
    import ext_lim_pkg::*;
#(
    parameter int LAYERS = 8,
    parameter int KMAX   = 16,
    parameter int BETA_W = 12,
    parameter int INV_W  = 16,
    parameter int FRAC   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [1:0]                  mode,
    input  logic [BETA_W-1:0]           beta,
    input  logic [$clog2(KMAX+1)-1:0]   num_parents,
    input  logic [LAYERS*INV_W-1:0]     inv_gain,
    input  logic [$clog2(LAYERS)-1:0]   rd_layer,
    input  logic [$clog2(KMAX)-1:0]     rd_rank,
    output logic [LIM_W-1:0]            rd_limit,
    output logic                        busy,
    output logic                        done
);

    localparam int LAY_W  = $clog2(LAYERS);
    localparam int KIDX_W = $clog2(KMAX);
    localparam int NPAR_W = $clog2(KMAX + 1);

    logic                     cap_en;
    logic                     wr_en;
    logic [LAY_W-1:0]         layer_idx;
    logic [KIDX_W-1:0]        rank_idx;
    logic [1:0]               mode_q;
    logic [BETA_W-1:0]        beta_q;
    logic [NPAR_W-1:0]        npar_q;
    logic [LAYERS*INV_W-1:0]  inv_q;
    logic [INV_W-1:0]         inv_cur;
    logic [LIM_W-1:0]         wr_data;
    logic [LIM_W-1:0]         omega_q;

    lim_seq #(.LAYERS(LAYERS), .KMAX(KMAX)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .busy      (busy),
        .done      (done),
        .cap_en    (cap_en),
        .wr_en     (wr_en),
        .layer_idx (layer_idx),
        .rank_idx  (rank_idx)
    );

    // Capture frame inputs when a start is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            beta_q <= '0;
            npar_q <= '0;
            inv_q  <= '0;
        end else if (cap_en) begin
            mode_q <= mode;
            beta_q <= beta;
            npar_q <= num_parents;
            inv_q  <= inv_gain;
        end
    end

    // Select the current layer's gain and the active constellation size
    always_comb begin
        inv_cur = inv_q[32'(layer_idx)*INV_W +: INV_W];
        omega_q = omega_of(cst_mode_e'(mode_q));
    end

    lim_arith #(.KMAX(KMAX), .BETA_W(BETA_W), .INV_W(INV_W), .FRAC(FRAC)) i_arith (
        .mode        (mode_q),
        .beta        (beta_q),
        .inv_gain    (inv_cur),
        .num_parents (npar_q),
        .rank_idx    (rank_idx),
        .limit       (wr_data)
    );

    lim_table #(.LAYERS(LAYERS), .KMAX(KMAX)) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_layer (layer_idx),
        .wr_rank  (rank_idx),
        .wr_data  (wr_data),
        .rd_layer (rd_layer),
        .rd_rank  (rd_rank),
        .rd_data  (rd_limit)
    );

    assert_clamp_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data <= omega_q));

    assert_unused_rank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(rank_idx) >= 32'(npar_q))) |-> (wr_data == '0));

    assert_rank_monotone_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && rank_idx != '0) |-> (wr_data <= $past(wr_data)));

    assert_capture_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(beta_q) && $stable(mode_q) &&
                                   $stable(npar_q) && $stable(inv_q)));

endmodule

// File: tb/test_ext_limit_calc.sv
`timescale 1ns/1ps
module test_ext_limit_calc;

    localparam int L = 8;
    localparam int K = 16;
    localparam int NENT = L * K;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = '0;
    logic [11:0]   beta = '0;
    logic [4:0]    num_parents = '0;
    logic [127:0]  inv_gain = '0;
    logic [2:0]    rd_layer = '0;
    logic [3:0]    rd_rank = '0;
    logic [3:0]    rd_limit;
    logic          busy;
    logic          done;

    int checks = 0;
    int failures = 0;

    // Stimulus of the frame under test, kept for the model
    int      f_mode, f_beta, f_npar;
    int      f_inv [L];

    ext_limit_calc i_ext_limit_calc (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .beta(beta),
        .num_parents(num_parents), .inv_gain(inv_gain), .rd_layer(rd_layer),
        .rd_rank(rd_rank), .rd_limit(rd_limit), .busy(busy), .done(done)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Real-valued reference for one entry; tag names the rule applied
    function automatic int model(input int md, input int bt, input int inv, input int rank,
                                 input int npar, output string tag);
        real om, v, f;
        om = (md == 0) ? 2.0 : (md == 1) ? 4.0 : 8.0;
        if (rank > ((npar > K) ? K : npar)) begin tag = "R7"; return 0; end
        v = (bt / 256.0) * (om - rank / om) * (inv / 256.0);
        if (v < 0.0) begin tag = "R5"; return 0; end
        f = $floor(v);
        if (f > om) begin tag = "R4"; return int'(om); end
        tag = "R3";
        return int'(f);
    endfunction

    task automatic read_entry(input int l, input int r, output int v);
        rd_layer = 3'(l);
        rd_rank  = 4'(r);
        #1;
        v = int'(rd_limit);
    endtask

    task automatic set_frame(input int md, input int bt, input int npar);
        f_mode = md; f_beta = bt; f_npar = npar;
        for (int l = 0; l < L; l++) begin
            int sz = 4 + int'($urandom % 13);
            f_inv[l] = int'($urandom % (32'd1 << sz));
        end
    endtask

    // Drive inputs and pulse start; returns at the negedge after the sampling edge
    task automatic launch();
        @(negedge clk);
        mode = 2'(f_mode); beta = 12'(f_beta); num_parents = 5'(f_npar);
        for (int l = 0; l < L; l++) inv_gain[l*16 +: 16] = 16'(f_inv[l]);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(inout int n);
        while (!done && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_table(input string extra);
        for (int l = 0; l < L; l++) begin
            for (int r = 0; r < K; r++) begin
                int v, e;
                string tag;
                e = model(f_mode, f_beta, f_inv[l], r + 1, f_npar, tag);
                read_entry(l, r, v);
                check(v == e, {tag, " ", extra}, v, e);
                if (r > 0) begin
                    int pv;
                    read_entry(l, r - 1, pv);
                    check(v <= pv, "R10 rank monotone", v, pv);
                end
            end
        end
    endtask

    task automatic run_frame(input string extra);
        int n = 0;
        launch();
        wait_done(n);
        check(n == NENT, "R2 completion latency", n, NENT);
        check(busy == 1'b0, "R2 busy low at done", int'(busy), 0);
        check_table(extra);
    endtask

    initial begin
        int n, v;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(busy == 1'b0 && done == 1'b0, "R1 status after reset", int'({busy, done}), 0);
        for (int l = 0; l < L; l++)
            for (int r = 0; r < K; r++) begin
                read_entry(l, r, v);
                check(v == 0, "R1 table cleared", v, 0);
            end

        // R3/R5 directed: M=2, beta=1.0, gain=1.0 -> 1,1,0,0, then negative
        set_frame(0, 256, 16);
        for (int l = 0; l < L; l++) f_inv[l] = 256;
        run_frame("R6 qpsk");
        read_entry(0, 0, v); check(v == 1, "R3 directed rank1", v, 1);
        read_entry(0, 2, v); check(v == 0, "R3 directed rank3", v, 0);
        read_entry(0, 4, v); check(v == 0, "R5 directed rank5", v, 0);

        // R9: done and table hold while idle; new start clears done
        repeat (10) @(negedge clk);
        check(done == 1'b1, "R9 done held", int'(done), 1);
        read_entry(3, 1, v); check(v == 1, "R9 table held", v, 1);

        // R4: everything saturates to 8
        set_frame(2, 4095, 16);
        for (int l = 0; l < L; l++) f_inv[l] = 65535;
        launch();
        check(done == 1'b0 && busy == 1'b1, "R9 start clears done", int'({busy, done}), 2);
        n = 1;
        @(negedge clk);
        wait_done(n);
        check(n == NENT, "R2 completion latency", n, NENT);
        check_table("R6 qam64");
        read_entry(7, 15, v); check(v == 8, "R4 directed saturation", v, 8);

        // R6: mode 3 behaves like 64-QAM
        set_frame(3, 300, 16);
        run_frame("R6 mode3");

        // R7: no parents, and more parents than the table holds
        set_frame(1, 2000, 0);
        run_frame("R7 zero parents");
        set_frame(1, 900, 31);
        run_frame("R7 oversized count");

        // R8: input changes and start during a run are ignored
        set_frame(1, 700, 9);
        launch();
        n = 0;
        for (int i = 0; i < 40; i++) begin
            if (i == 20) begin
                start = 1'b1; mode = 2'd0; beta = 12'd4095; num_parents = 5'd2;
                inv_gain = '1;
            end else begin
                start = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        wait_done(n);
        check(n == NENT, "R8 latency unaffected by mid-run start", n, NENT);
        check_table("R8 captured inputs");

        // Constrained random frames
        for (int t = 0; t < 20; t++) begin
            set_frame(int'($urandom % 4), int'($urandom % (32'd1 << (4 + $urandom % 9))),
                      int'($urandom % 20));
            run_frame("random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule